// File: doc/BRIEF.md
# Debug Authorisation Gate

This block decides which debug features stay enabled after boot. It takes two boot flags as inputs. One turns off all debug. The other turns off secure-world debug. It also takes the enrolment state of two debug keys (a secure key and a non-secure key), and a match indication for each key as supplied over the debug port. From these it computes one enable per debug feature. The features are secure and non-secure debug of each processor, plus a set of other debug features.

Software can override a disable through an override register. A companion lock register sets bits when 1s are written to it. Each set lock bit freezes the matching override bit until the next cold reset. Key comparison is done elsewhere: this block sees only the two match bits. All control and status pins are plain level signals with no handshake.

Feature bit layout, for `NUM_PROC=2` and `NUM_OTHER=1`:
- bit 2p is processor p secure debug.
- bit 2p+1 is processor p non-secure debug.
- bits from 2*NUM_PROC upward are the other features.

Key index 0 is the secure key and key index 1 is the non-secure key.

Top module: `dbg_auth_gate`

## Requirements
- R1: After cold reset the override and lock registers read all zeros. With no flag set and no key enrolled, every feature enable is 1.
- R2: While the all-debug-off flag is set, every feature enable is 0, unless every override bit is 1.
- R3: While the secure-debug-off flag is set, the secure enables (bits 0 and 2) are 0, unless both of those override bits are 1. The non-secure and other features are unaffected.
- R4: With exactly one key enrolled and that key not matched, every feature enable is 0, unless every override bit is 1.
- R5: With both keys enrolled and neither matched, every feature enable is 0, unless every override bit is 1.
- R6: With both keys enrolled and only the non-secure key (index 1) matched, the secure enables are 0, unless both secure override bits are 1.
- R7: With both keys enrolled and the secure key (index 0) matched, the key check disables nothing. Either boot flag still applies.
- R8: A write to the override register takes effect at the next clock edge. It changes only bits whose lock bit is 0; locked bits keep their value.
- R9: A lock write sets every lock bit written as 1. Writing 0 clears nothing; only cold reset clears lock bits.
- R10: A match on a key that is not enrolled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| flag_all_off | input | 1 | Boot flag: disable all debug |
| flag_sec_off | input | 1 | Boot flag: disable secure debug |
| key_enrolled | input | 2 | Enrolled keys (bit 0 secure, bit 1 non-secure) |
| key_match | input | 2 | Supplied key matched (same bit order) |
| ovr_wr | input | 1 | Write strobe for the override register |
| ovr_wdata | input | NUM_PROC*2+NUM_OTHER | Override write data |
| lock_wr | input | 1 | Write strobe for the lock register (write-1-to-set) |
| lock_wdata | input | NUM_PROC*2+NUM_OTHER | Lock bits to set |
| ovr_q | output | NUM_PROC*2+NUM_OTHER | Override register value |
| lock_q | output | NUM_PROC*2+NUM_OTHER | Lock register value |
| feat_en | output | NUM_PROC*2+NUM_OTHER | Per-feature debug enable |

## Verification
The bench targets overrides that are almost complete. An all-but-one override must leave everything off under the all-off flag or a key lockout. A gate that checked any bit instead of all bits would open the features early. A secure override must also fail to lift a full lockout; a design that mixed up the two override scopes would re-enable secure debug there.

The key cases are walked one by one:
- single key enrolled;
- both keys, with no match;
- both keys, with only the non-secure match;
- both keys, with the secure match.

A match on a key that is not enrolled must not unlock anything. A design that used raw matches would leak debug access here.

For the registers, the bench writes over locked bits and writes zeros to the lock register. A design with a non-sticky lock, or with a lock that fails to hold, would show a changed value.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int KEY_SEC = 0;
  localparam int KEY_NS  = 1;

  typedef struct packed {
    logic all_off;
    logic sec_off;
  } gate_cause_t;
endpackage

// File: rtl/dbg_ovr_regs.sv
module dbg_ovr_regs #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ovr_wr,
  input  logic [W-1:0] ovr_wdata,
  input  logic         lock_wr,
  input  logic [W-1:0] lock_wdata,
  output logic [W-1:0] ovr_q,
  output logic [W-1:0] lock_q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ovr_q[i]  <= 1'b0;
          lock_q[i] <= 1'b0;
        end else begin
          if (ovr_wr && !lock_q[i]) ovr_q[i] <= ovr_wdata[i];
          if (lock_wr && lock_wdata[i]) lock_q[i] <= 1'b1;
        end
      end

      assert_locked_bit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[i] |=> $stable(ovr_q[i]));
      assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[i] |=> lock_q[i]);
    end
  endgenerate
endmodule

// File: rtl/dbg_key_eval.sv
module dbg_key_eval
  import dbg_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  key_enrolled,
  input  logic [1:0]  key_match,
  output gate_cause_t cause
);
  logic [1:0] hit;
  assign hit = key_match & key_enrolled;

  always_comb begin
    cause = '0;
    if (^key_enrolled) begin
      cause.all_off = (hit == 2'b00);
    end else if (&key_enrolled) begin
      if (hit == 2'b00)
        cause.all_off = 1'b1;
      else if (!hit[KEY_SEC])
        cause.sec_off = 1'b1;
    end
  end

  assert_cause_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cause.all_off && cause.sec_off));
  assert_no_keys_no_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_enrolled == 2'b00) |-> (cause == '0));
endmodule

// File: rtl/dbg_feat_mask.sv
module dbg_feat_mask
  import dbg_gate_pkg::*;
#(
  parameter int NUM_PROC  = 2,
  parameter int NUM_OTHER = 1,
  localparam int W = NUM_PROC*2 + NUM_OTHER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_all_off,
  input  logic         flag_sec_off,
  input  gate_cause_t  key_cause,
  input  logic [W-1:0] ovr,
  output logic [W-1:0] feat_en
);
  logic [W-1:0] sec_mask;
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_mask
      if (i < NUM_PROC*2 && (i % 2) == 0) begin : g_sec
        assign sec_mask[i] = 1'b1;
      end else begin : g_other
        assign sec_mask[i] = 1'b0;
      end
    end
  endgenerate

  logic full_ovr, sec_ovr, all_off, sec_off;
  assign full_ovr = &ovr;
  assign sec_ovr  = ((ovr & sec_mask) == sec_mask);
  assign all_off  = (flag_all_off | key_cause.all_off) & ~full_ovr;
  assign sec_off  = (flag_sec_off | key_cause.sec_off) & ~sec_ovr;
  assign feat_en  = all_off ? '0 : (sec_off ? ~sec_mask : '1);

  assert_flag_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_all_off && !(&ovr)) |-> (feat_en == '0));
  assert_flag_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sec_off && ((ovr & sec_mask) != sec_mask)) |-> ((feat_en & sec_mask) == '0));
  assert_full_ovr_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&ovr) |-> (feat_en == '1));
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dbg_gate_pkg::*;
#(
  parameter int NUM_PROC  = 2,
  parameter int NUM_OTHER = 1,
  localparam int W = NUM_PROC*2 + NUM_OTHER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_all_off,
  input  logic         flag_sec_off,
  input  logic [1:0]   key_enrolled,
  input  logic [1:0]   key_match,
  input  logic         ovr_wr,
  input  logic [W-1:0] ovr_wdata,
  input  logic         lock_wr,
  input  logic [W-1:0] lock_wdata,
  output logic [W-1:0] ovr_q,
  output logic [W-1:0] lock_q,
  output logic [W-1:0] feat_en
);
  gate_cause_t key_cause;

  dbg_ovr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .lock_wr(lock_wr), .lock_wdata(lock_wdata),
    .ovr_q(ovr_q), .lock_q(lock_q)
  );

  dbg_key_eval u_keys (
    .clk(clk), .rst_n(rst_n),
    .key_enrolled(key_enrolled), .key_match(key_match),
    .cause(key_cause)
  );

  dbg_feat_mask #(.NUM_PROC(NUM_PROC), .NUM_OTHER(NUM_OTHER)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .flag_all_off(flag_all_off), .flag_sec_off(flag_sec_off),
    .key_cause(key_cause), .ovr(ovr_q),
    .feat_en(feat_en)
  );
endmodule

// File: tb/dbg_auth_gate_test.sv
module dbg_auth_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_all_off = 1'b0, flag_sec_off = 1'b0;
  logic [1:0] key_enrolled = '0, key_match = '0;
  logic ovr_wr = 1'b0, lock_wr = 1'b0;
  logic [W-1:0] ovr_wdata = '0, lock_wdata = '0;
  logic [W-1:0] ovr_q, lock_q, feat_en;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_auth_gate uut (
    .clk(clk), .rst_n(rst_n),
    .flag_all_off(flag_all_off), .flag_sec_off(flag_sec_off),
    .key_enrolled(key_enrolled), .key_match(key_match),
    .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .lock_wr(lock_wr), .lock_wdata(lock_wdata),
    .ovr_q(ovr_q), .lock_q(lock_q), .feat_en(feat_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic write_ovr(input logic [W-1:0] d);
    @(negedge clk);
    ovr_wr = 1'b1; ovr_wdata = d;
    @(negedge clk);
    ovr_wr = 1'b0;
  endtask

  task automatic write_lock(input logic [W-1:0] d);
    @(negedge clk);
    lock_wr = 1'b1; lock_wdata = d;
    @(negedge clk);
    lock_wr = 1'b0;
  endtask

  task automatic clear_inputs();
    flag_all_off = 0; flag_sec_off = 0; key_enrolled = 0; key_match = 0;
    write_ovr('0);
  endtask

  task automatic t_reset();
    settle();
    chk("R1 ovr", ovr_q, '0);
    chk("R1 lock", lock_q, '0);
    chk("R1 feat", feat_en, 5'b11111);
  endtask

  task automatic t_flag_all();
    flag_all_off = 1; settle();
    chk("R2 flag", feat_en, 5'b00000);
    write_ovr(5'b11110); settle();
    chk("R2 partial override", feat_en, 5'b00000);
    write_ovr(5'b11111); settle();
    chk("R2 full override", feat_en, 5'b11111);
    clear_inputs();
  endtask

  task automatic t_flag_sec();
    flag_sec_off = 1; settle();
    chk("R3 flag", feat_en, 5'b11010);
    write_ovr(5'b00001); settle();
    chk("R3 one secure override", feat_en, 5'b11010);
    write_ovr(5'b00101); settle();
    chk("R3 secure override", feat_en, 5'b11111);
    clear_inputs();
  endtask

  task automatic t_one_key();
    key_enrolled = 2'b01; key_match = 2'b00; settle();
    chk("R4 secure only unmatched", feat_en, 5'b00000);
    key_match = 2'b01; settle();
    chk("R4 secure only matched", feat_en, 5'b11111);
    key_enrolled = 2'b10; key_match = 2'b10; settle();
    chk("R4 ns only matched", feat_en, 5'b11111);
    key_match = 2'b01; settle();
    chk("R10 unenrolled match", feat_en, 5'b00000);
    write_ovr(5'b00101); settle();
    chk("R4 secure override insufficient", feat_en, 5'b00000);
    write_ovr(5'b11111); settle();
    chk("R4 full override", feat_en, 5'b11111);
    clear_inputs();
  endtask

  task automatic t_both_none();
    key_enrolled = 2'b11; key_match = 2'b00; settle();
    chk("R5 both no match", feat_en, 5'b00000);
    write_ovr(5'b11111); settle();
    chk("R5 full override", feat_en, 5'b11111);
    clear_inputs();
  endtask

  task automatic t_both_ns();
    key_enrolled = 2'b11; key_match = 2'b10; settle();
    chk("R6 ns match", feat_en, 5'b11010);
    write_ovr(5'b00101); settle();
    chk("R6 secure override", feat_en, 5'b11111);
    clear_inputs();
  endtask

  task automatic t_both_sec();
    key_enrolled = 2'b11; key_match = 2'b01; settle();
    chk("R7 secure match", feat_en, 5'b11111);
    key_match = 2'b11; settle();
    chk("R7 both match", feat_en, 5'b11111);
    flag_sec_off = 1; settle();
    chk("R7 sec flag still applies", feat_en, 5'b11010);
    flag_sec_off = 0; flag_all_off = 1; settle();
    chk("R7 all flag still applies", feat_en, 5'b00000);
    clear_inputs();
  endtask

  task automatic t_lock();
    write_lock(5'b00001); settle();
    chk("R9 lock set", lock_q, 5'b00001);
    write_ovr(5'b11111); settle();
    chk("R8 locked bit kept", ovr_q, 5'b11110);
    write_lock(5'b00000); settle();
    chk("R9 zero write keeps lock", lock_q, 5'b00001);
    write_lock(5'b10000); settle();
    chk("R9 lock accumulates", lock_q, 5'b10001);
    write_ovr(5'b00000); settle();
    chk("R8 unlocked bits written", ovr_q, 5'b10000);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    settle();
    chk("R9 reset clears lock", lock_q, 5'b00000);
    chk("R1 reset clears ovr", ovr_q, 5'b00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_flag_all();
    t_flag_sec();
    t_one_key();
    t_both_none();
    t_both_ns();
    t_both_sec();
    t_lock();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule